// File: doc/BRIEF.md
# Raster Timing Generator with Frame-Synchronous Register Update

This block produces the horizontal sync, vertical sync, data-enable and pixel coordinate signals that pace a parallel RGB display pipe. Every line is built from four consecutive regions: the sync pulse, the back porch, the active pixels and the front porch. Every frame is built from the same four regions counted in lines. Software programs the geometry through a plain write port of valid, address and data.

Timing writes first land in shadow registers. While the generator runs, the shadow contents are copied into the live timing registers only at the boundary between two frames, so a frame never mixes old and new geometry. While the generator is stopped, the live registers follow the shadows on the next cycle. The timing state is split into four update units: horizontal, vertical, active size and polarity. Each unit has a freeze bit that holds back its copy. A frame-end interrupt has its own enable, a pending flag and a write-one-to-clear register.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, hsync, vsync, de, px_x, px_y, irq and irq_pending are all 0. Polarity resets to non-inverted and the generator resets stopped.
- R2: Each line starts with a sync region of (HSW code + 1) clocks, where the HSW register is at address 2 with its code in bits [11:0]. Next come the back porch and (width code + 1) active clocks, then the front porch. The back porch is HTIM bits [27:16] and the front porch is HTIM bits [11:0], with HTIM at address 1. Porch values are taken as written, and zero is allowed.
- R3: Each frame is built from lines in the same order: a vsync region, the vertical back porch, (height code + 1) active lines and the vertical front porch. The vertical porches sit in VTIM at address 3, back porch in bits [27:16] and front porch in bits [11:0]. SIZE at address 5 holds the height code in bits [27:16] and the width code in bits [11:0].
- R4: de is 1 only when both the horizontal and the vertical position are in their active regions. During de, px_x and px_y count from 0 at the first active pixel and the first active line. Outside de, both are 0.
- R5: The vsync width code is written at address 4 and is limited to 4 bits. Any written value above 14 is stored as 14, so vsync lasts at most 15 lines.
- R6: In the POL register at address 6, bit 0 inverts vsync and bit 1 inverts hsync. An inverted sync line idles at 1 and pulses to 0.
- R7: Bit 0 of CTRL at address 0 is the run bit. While it is set, timing writes take effect only from the frame after the one in which they were written. While it is clear, they take effect on the next cycle.
- R8: Each update unit u has a freeze bit in the register at address 9 + u/32, at bit position u%32. The units are: 0 horizontal (HTIM and HSW), 1 vertical (VTIM and VSW), 2 SIZE, 3 POL. While a unit's freeze bit is set, its live values keep their old contents at every frame end. After the bit is cleared, the unit picks up its shadow values at the next frame end.
- R9: Setting the run bit starts the generator on the first cycle of a frame, with both syncs active. Clearing it parks hsync and vsync at their idle levels and holds de, px_x and px_y at 0.
- R10: irq_pending becomes 1 on the cycle after the last pixel clock of each frame. irq equals irq_pending AND bit 0 of IRQEN at address 7. Writing 1 in bit 0 to address 8 clears irq_pending, and writing 0 there has no effect. A frame end in the same cycle as a clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register word address |
| wr_data | input | DATA_W | Register write data |
| hsync | output | 1 | Horizontal sync, polarity per POL bit 1 |
| vsync | output | 1 | Vertical sync, polarity per POL bit 0 |
| de | output | 1 | Active pixel indicator |
| px_x | output | HW | Column inside the active area |
| px_y | output | VW | Row inside the active area |
| irq | output | 1 | Masked frame-end interrupt |
| irq_pending | output | 1 | Unmasked frame-end status |

## Verification
The bench runs several geometries, including zero porches, inverted polarity and an oversized vsync code, and compares every pixel clock of each frame with a position model. A generator that put the regions in the wrong order, dropped the minus-one encoding or skipped the clamp would fail that comparison.

A timing write in the middle of a frame is then checked by measuring frame periods. A design that applied the write at once would shorten or stretch the frame in which it was written. A design that ignored the freeze bit, or decoded the wrong bit position, would change period while the unit is supposed to be held. The interrupt checks confirm three points: a masked pending flag never reaches irq, a clear written with 0 leaves the flag set, and parking the generator idles the syncs at their inverted levels.

// File: rtl/disp_tg_pkg.sv
package disp_tg_pkg;

   // upper field of every two-field timing word starts here
   localparam int unsigned HI_LSB       = 16;
   // vertical sync code width and its saturation value
   localparam int unsigned VSW_W        = 4;
   localparam int unsigned VSW_MAX_CODE = 14;

   // word addresses of the write port
   localparam int unsigned ADR_CTRL   = 0;
   localparam int unsigned ADR_HTIM   = 1;
   localparam int unsigned ADR_HSW    = 2;
   localparam int unsigned ADR_VTIM   = 3;
   localparam int unsigned ADR_VSW    = 4;
   localparam int unsigned ADR_SIZE   = 5;
   localparam int unsigned ADR_POL    = 6;
   localparam int unsigned ADR_IRQEN  = 7;
   localparam int unsigned ADR_IRQCLR = 8;
   localparam int unsigned ADR_FRZ    = 9;

   // update units, each with one freeze bit
   localparam int unsigned U_HOR     = 0;
   localparam int unsigned U_VER     = 1;
   localparam int unsigned U_SIZE    = 2;
   localparam int unsigned U_POL     = 3;
   localparam int unsigned NUM_UNITS = 4;
   localparam int unsigned FRZ_REGS  = (NUM_UNITS + 31) / 32;

   // bit 0 inverts vsync, bit 1 inverts hsync
   typedef struct packed {
      logic inv_h;
      logic inv_v;
   } pol_t;

endpackage

// File: rtl/tg_axis.sv
// One timing axis: sync, back porch, active, front porch, then wrap.
module tg_axis
   import disp_tg_pkg::*;
#(
   parameter int unsigned FW = 12,
   parameter int unsigned SW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          step,
   input  logic [SW-1:0] sync_code,
   input  logic [FW-1:0] bp,
   input  logic [FW-1:0] act_code,
   input  logic [FW-1:0] fp,
   output logic          in_sync,
   output logic          in_act,
   output logic          last,
   output logic [FW-1:0] pos
);

   localparam int unsigned CW = FW + 2;

   if (SW > FW) begin : g_bad_sw
      $error("tg_axis: sync code wider than field width");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] b_sync;
   logic [CW-1:0] b_bp;
   logic [CW-1:0] b_act;
   logic [CW-1:0] b_end;

   always_comb begin
      b_sync = CW'(sync_code) + CW'(1);
      b_bp   = b_sync + CW'(bp);
      b_act  = b_bp + CW'(act_code) + CW'(1);
      b_end  = b_act + CW'(fp);
   end

   assign in_sync = (cnt < b_sync);
   assign in_act  = (cnt >= b_bp) && (cnt < b_act);
   assign last    = (cnt >= b_end - CW'(1));
   assign pos     = in_act ? FW'(cnt - b_bp) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!en) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= last ? '0 : cnt + CW'(1);
      end
   end

endmodule

// File: rtl/tg_regs.sv
// Write decode, shadow registers, per-unit freeze and live copy.
module tg_regs
   import disp_tg_pkg::*;
#(
   parameter int unsigned HW     = 12,
   parameter int unsigned VW     = 12,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              frame_end,
   output logic              en,
   output logic [HW-1:0]     lv_hsw,
   output logic [HW-1:0]     lv_hbp,
   output logic [HW-1:0]     lv_hfp,
   output logic [HW-1:0]     lv_w,
   output logic [VW-1:0]     lv_vbp,
   output logic [VW-1:0]     lv_vfp,
   output logic [VW-1:0]     lv_h,
   output logic [VSW_W-1:0]  lv_vsw,
   output pol_t              lv_pol
);

   logic [HW-1:0]    sh_hsw, sh_hbp, sh_hfp, sh_w;
   logic [VW-1:0]    sh_vbp, sh_vfp, sh_h;
   logic [VSW_W-1:0] sh_vsw;
   pol_t             sh_pol;
   logic [NUM_UNITS-1:0] frz;
   logic             upd;
   logic             unused_wr_bits;

   assign unused_wr_bits = ^wr_data;
   assign upd = !en || frame_end;

   // run bit acts at once, timing words land in the shadows
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         sh_hsw <= '0;
         sh_hbp <= '0;
         sh_hfp <= '0;
         sh_w   <= '0;
         sh_vbp <= '0;
         sh_vfp <= '0;
         sh_h   <= '0;
         sh_vsw <= '0;
         sh_pol <= '0;
      end else if (wr_valid) begin
         case (wr_addr)
            ADDR_W'(ADR_CTRL): en <= wr_data[0];
            ADDR_W'(ADR_HTIM): begin
               sh_hbp <= wr_data[HI_LSB +: HW];
               sh_hfp <= wr_data[HW-1:0];
            end
            ADDR_W'(ADR_HSW):  sh_hsw <= wr_data[HW-1:0];
            ADDR_W'(ADR_VTIM): begin
               sh_vbp <= wr_data[HI_LSB +: VW];
               sh_vfp <= wr_data[VW-1:0];
            end
            ADDR_W'(ADR_VSW):
               sh_vsw <= (wr_data > DATA_W'(VSW_MAX_CODE)) ?
                         VSW_W'(VSW_MAX_CODE) : wr_data[VSW_W-1:0];
            ADDR_W'(ADR_SIZE): begin
               sh_h <= wr_data[HI_LSB +: VW];
               sh_w <= wr_data[HW-1:0];
            end
            ADDR_W'(ADR_POL):  sh_pol <= wr_data[1:0];
            default: ;
         endcase
      end
   end

   // freeze bits: unit u lives at register u/32, bit u%32
   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_frz
      logic hold;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold <= 1'b0;
         end else if (wr_valid && wr_addr == ADDR_W'(ADR_FRZ + u / 32)) begin
            hold <= wr_data[u % 32];
         end
      end
      assign frz[u] = hold;
   end

   // live copy per unit
   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      logic take;
      assign take = upd && !frz[u];
      if (u == U_HOR) begin : g_hor
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lv_hsw <= '0;
               lv_hbp <= '0;
               lv_hfp <= '0;
            end else if (take) begin
               lv_hsw <= sh_hsw;
               lv_hbp <= sh_hbp;
               lv_hfp <= sh_hfp;
            end
         end
      end else if (u == U_VER) begin : g_ver
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lv_vsw <= '0;
               lv_vbp <= '0;
               lv_vfp <= '0;
            end else if (take) begin
               lv_vsw <= sh_vsw;
               lv_vbp <= sh_vbp;
               lv_vfp <= sh_vfp;
            end
         end
      end else if (u == U_SIZE) begin : g_size
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lv_w <= '0;
               lv_h <= '0;
            end else if (take) begin
               lv_w <= sh_w;
               lv_h <= sh_h;
            end
         end
      end else begin : g_pol
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lv_pol <= '0;
            end else if (take) begin
               lv_pol <= sh_pol;
            end
         end
      end
   end

endmodule

// File: rtl/tg_irq.sv
// Frame-end pending flag, mask and write-one-to-clear.
module tg_irq
   import disp_tg_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_bit0,
   input  logic              frame_end,
   output logic              irq,
   output logic              pending
);

   logic mask_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_en <= 1'b0;
      end else if (wr_valid && wr_addr == ADDR_W'(ADR_IRQEN)) begin
         mask_en <= wr_bit0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
      end else if (frame_end) begin
         pending <= 1'b1;
      end else if (wr_valid && wr_addr == ADDR_W'(ADR_IRQCLR) && wr_bit0) begin
         pending <= 1'b0;
      end
   end

   assign irq = pending && mask_en;

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
   import disp_tg_pkg::*;
#(
   parameter int unsigned HW     = 12,
   parameter int unsigned VW     = 12,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic [HW-1:0]     px_x,
   output logic [VW-1:0]     px_y,
   output logic              irq,
   output logic              irq_pending
);

   localparam int unsigned MAXW = (HW > VW) ? HW : VW;

   if (HW > HI_LSB || VW > HI_LSB) begin : g_bad_field
      $error("disp_timing_gen: field wider than the low half of a word");
   end
   if (DATA_W < HI_LSB + MAXW || DATA_W < 32) begin : g_bad_data
      $error("disp_timing_gen: data word too narrow");
   end
   if ((1 << ADDR_W) < ADR_FRZ + FRZ_REGS) begin : g_bad_addr
      $error("disp_timing_gen: address space too small");
   end
   if (HW < VSW_W) begin : g_bad_hw
      $error("disp_timing_gen: horizontal field narrower than sync code");
   end

   logic             en;
   logic [HW-1:0]    lv_hsw, lv_hbp, lv_hfp, lv_w;
   logic [VW-1:0]    lv_vbp, lv_vfp, lv_h;
   logic [VSW_W-1:0] lv_vsw;
   pol_t             lv_pol;
   logic             frame_end;
   logic             h_sync, h_act, h_last;
   logic             v_sync, v_act, v_last;
   logic [HW-1:0]    h_pos;
   logic [VW-1:0]    v_pos;

   tg_regs #(.HW(HW), .VW(VW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (wr_valid),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .frame_end (frame_end),
      .en        (en),
      .lv_hsw    (lv_hsw),
      .lv_hbp    (lv_hbp),
      .lv_hfp    (lv_hfp),
      .lv_w      (lv_w),
      .lv_vbp    (lv_vbp),
      .lv_vfp    (lv_vfp),
      .lv_h      (lv_h),
      .lv_vsw    (lv_vsw),
      .lv_pol    (lv_pol)
   );

   tg_axis #(.FW(HW), .SW(HW)) u_hor (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .step      (1'b1),
      .sync_code (lv_hsw),
      .bp        (lv_hbp),
      .act_code  (lv_w),
      .fp        (lv_hfp),
      .in_sync   (h_sync),
      .in_act    (h_act),
      .last      (h_last),
      .pos       (h_pos)
   );

   tg_axis #(.FW(VW), .SW(VSW_W)) u_ver (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .step      (h_last),
      .sync_code (lv_vsw),
      .bp        (lv_vbp),
      .act_code  (lv_h),
      .fp        (lv_vfp),
      .in_sync   (v_sync),
      .in_act    (v_act),
      .last      (v_last),
      .pos       (v_pos)
   );

   tg_irq #(.ADDR_W(ADDR_W)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (wr_valid),
      .wr_addr   (wr_addr),
      .wr_bit0   (wr_data[0]),
      .frame_end (frame_end),
      .irq       (irq),
      .pending   (irq_pending)
   );

   assign frame_end = en && h_last && v_last;

   assign hsync = (en && h_sync) ^ lv_pol.inv_h;
   assign vsync = (en && v_sync) ^ lv_pol.inv_v;
   assign de    = en && h_act && v_act;
   assign px_x  = de ? h_pos : '0;
   assign px_y  = de ? v_pos : '0;

endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
   parameter int unsigned HW = 12,
   parameter int unsigned VW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en,
   input logic          frame_end,
   input logic          irq_pending,
   input logic          hsync,
   input logic          vsync,
   input logic          de,
   input logic [HW-1:0] px_x,
   input logic [VW-1:0] px_y,
   input logic          inv_h,
   input logic          inv_v,
   input logic [3*HW-1:0] live_h,
   input logic [3:0]    live_vsw
);

   logic hs_act, vs_act;
   assign hs_act = hsync ^ inv_h;
   assign vs_act = vsync ^ inv_v;

   assert_de_outside_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (!hs_act && !vs_act));

   assert_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!de && px_x == '0 && px_y == '0 && !hs_act && !vs_act));

   assert_start_on_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> (hs_act && vs_act));

   assert_pending_from_frame_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pending && !$past(irq_pending)) |-> $past(frame_end));

   assert_hold_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !frame_end) |=> $stable(live_h));

   assert_vsw_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      live_vsw <= 4'd14);

endmodule

bind disp_timing_gen tg_checker #(.HW(HW), .VW(VW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (en),
   .frame_end   (frame_end),
   .irq_pending (irq_pending),
   .hsync       (hsync),
   .vsync       (vsync),
   .de          (de),
   .px_x        (px_x),
   .px_y        (px_y),
   .inv_h       (lv_pol.inv_h),
   .inv_v       (lv_pol.inv_v),
   .live_h      ({lv_hsw, lv_hbp, lv_hfp}),
   .live_vsw    (lv_vsw)
);

// File: tb/tb_disp_timing_gen.sv
module tb_disp_timing_gen;

   localparam int CLK_P  = 10;
   localparam int HW     = 12;
   localparam int VW     = 12;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 32;

   // hsw hbp w hfp vcode vlines vbp h vfp pol frame_len de_count
   localparam int MODE_TAB [3][12] = '{
      '{2, 1, 4, 1,  0,  1, 1, 2, 1, 0,  40,  8},
      '{1, 0, 3, 0,  1,  2, 0, 1, 2, 3,  20,  3},
      '{3, 2, 5, 2, 20, 15, 1, 3, 0, 1, 228, 15}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_valid = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              hsync, vsync, de, irq, irq_pending;
   logic [HW-1:0]     px_x;
   logic [VW-1:0]     px_y;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   disp_timing_gen #(.HW(HW), .VW(VW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_valid    (wr_valid),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .hsync       (hsync),
      .vsync       (vsync),
      .de          (de),
      .px_x        (px_x),
      .px_y        (px_y),
      .irq         (irq),
      .irq_pending (irq_pending)
   );

   // frame monitor, valid while vsync is not inverted
   int  cyc = 0;
   int  last_start = 0;
   int  meas_period = 0;
   int  frames = 0;
   logic prev_vs = 1'b0;
   always @(negedge clk) begin
      cyc <= cyc + 1;
      prev_vs <= vsync;
      if (vsync && !prev_vs) begin
         meas_period <= cyc - last_start;
         last_start  <= cyc;
         frames      <= frames + 1;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a falling edge, returns at the next falling edge
   task automatic wr(input int a, input int d);
      wr_valid = 1'b1;
      wr_addr  = ADDR_W'(a);
      wr_data  = DATA_W'(d);
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic wait_frames(input int n);
      int target;
      target = frames + n;
      while (frames < target) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(hsync == 1'b0 && vsync == 1'b0, "R1 syncs", {hsync, vsync}, 0);
      check(de == 1'b0 && px_x == '0 && px_y == '0, "R1 de/coords", de, 0);
      check(irq == 1'b0 && irq_pending == 1'b0, "R1 irq", {irq, irq_pending}, 0);

      // table of geometries, one frame each against a position model
      for (int m = 0; m < 3; m++) begin
         int hsw, hbp, w, hfp, vl, vbp, h, vfp, pol, flen, ht;
         int e_hs, e_vs, e_de, e_xy, de_cnt;
         bit pend_before;
         hsw = MODE_TAB[m][0]; hbp = MODE_TAB[m][1]; w = MODE_TAB[m][2];
         hfp = MODE_TAB[m][3]; vl = MODE_TAB[m][5];  vbp = MODE_TAB[m][6];
         h = MODE_TAB[m][7];   vfp = MODE_TAB[m][8]; pol = MODE_TAB[m][9];
         flen = MODE_TAB[m][10];
         ht = hsw + hbp + w + hfp;
         e_hs = 0; e_vs = 0; e_de = 0; e_xy = 0; de_cnt = 0;
         pend_before = 1'b1;
         wr(0, 0);
         wr(1, (hbp << 16) | hfp);
         wr(2, hsw - 1);
         wr(3, (vbp << 16) | vfp);
         wr(4, MODE_TAB[m][4]);
         wr(5, ((h - 1) << 16) | (w - 1));
         wr(6, pol);
         wr(8, 1);
         wr(7, 1);
         wr(0, 1);
         // R9 first enabled cycle is the first sync clock
         check((hsync ^ pol[1]) && (vsync ^ pol[0]), "R9 start", {hsync, vsync}, 3);
         for (int t = 0; t < flen; t++) begin
            int hp, vp;
            bit xd, xh, xv;
            hp = t % ht;
            vp = t / ht;
            xh = (hp < hsw);
            xv = (vp < vl);
            xd = (hp >= hsw + hbp) && (hp < hsw + hbp + w) &&
                 (vp >= vl + vbp) && (vp < vl + vbp + h);
            if (hsync !== (xh ^ pol[1])) e_hs++;
            if (vsync !== (xv ^ pol[0])) e_vs++;
            if (de !== xd) e_de++;
            if (xd) begin
               if (px_x !== HW'(hp - hsw - hbp) || px_y !== VW'(vp - vl - vbp)) e_xy++;
            end else if (px_x !== '0 || px_y !== '0) e_xy++;
            if (de) de_cnt++;
            if (t == flen - 1) pend_before = irq_pending;
            @(negedge clk);
         end
         check(e_hs == 0, "R2 R6 hsync shape", e_hs, 0);
         check(e_vs == 0, "R3 R5 R6 vsync shape", e_vs, 0);
         check(e_de == 0, "R4 de window", e_de, 0);
         check(e_xy == 0, "R4 coordinates", e_xy, 0);
         check(de_cnt == MODE_TAB[m][11], "R3 active pixels", de_cnt, MODE_TAB[m][11]);
         check(pend_before == 1'b0, "R10 no early pending", pend_before, 0);
         check(irq_pending == 1'b1 && irq == 1'b1, "R10 frame end irq", {irq, irq_pending}, 3);
      end

      // R7 shadowing: mid-frame write waits for the frame boundary
      wr(0, 0);
      wr(1, (1 << 16) | 1);
      wr(2, 1);
      wr(3, (1 << 16) | 1);
      wr(4, 0);
      wr(5, (1 << 16) | 3);
      wr(6, 0);
      @(negedge clk);
      wr(0, 1);
      wait_frames(2);
      repeat (5) @(negedge clk);
      wr(1, (1 << 16) | 3);
      wait_frames(1);
      check(meas_period == 40, "R7 old frame kept", meas_period, 40);
      wait_frames(1);
      check(meas_period == 50, "R7 new frame applied", meas_period, 50);

      // R8 freeze horizontal unit (register 9, bit 0)
      wr(9, 1);
      wr(1, (1 << 16) | 1);
      wait_frames(3);
      check(meas_period == 50, "R8 horizontal frozen", meas_period, 50);
      wr(9, 0);
      wait_frames(2);
      check(meas_period == 40, "R8 horizontal released", meas_period, 40);

      // R8 freeze vertical unit (register 9, bit 1)
      wr(9, 2);
      wr(3, (1 << 16) | 3);
      wait_frames(3);
      check(meas_period == 40, "R8 vertical frozen", meas_period, 40);
      wr(9, 0);
      wait_frames(2);
      check(meas_period == 56, "R8 vertical released", meas_period, 56);

      // R10 mask and write-one-to-clear
      wr(7, 0);
      wr(8, 1);
      wait_frames(1);
      @(negedge clk);
      check(irq_pending == 1'b1, "R10 pending set", irq_pending, 1);
      check(irq == 1'b0, "R10 masked", irq, 0);
      wr(8, 0);
      check(irq_pending == 1'b1, "R10 zero write ignored", irq_pending, 1);
      wr(8, 1);
      check(irq_pending == 1'b0, "R10 cleared", irq_pending, 0);

      // R9 park with inverted polarity
      wr(0, 0);
      wr(6, 3);
      @(negedge clk);
      check(hsync == 1'b1 && vsync == 1'b1, "R9 R6 parked idle", {hsync, vsync}, 3);
      repeat (7) @(negedge clk);
      check(de == 1'b0 && px_x == '0 && px_y == '0, "R9 parked de", de, 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule